// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps the processor's status word. One part holds four condition flags taken from the arithmetic unit: carry, overflow, negative and zero. They are refreshed from the current result whenever the datapath pulses an update strobe. The other part holds three control fields: an interrupt-enable bit, a multi-bit execution priority and an execution mode. Only privileged code may change these fields. A read port always presents the whole packed word, and it reflects every change one clock after the edge that made it.

The flag input acts as a stream with one valid signal and no back-pressure. The block is always ready, so every strobed result is taken on the edge where the strobe is high. No ready pin exists because no such cycle can stall. The control write port is a plain write enable. If it is raised while the unit is in a non-kernel mode, nothing is written and a one-cycle reject pulse follows. The only way back to kernel mode from user mode is reset; trapping and interrupt delivery belong to other blocks.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset the status word is 0x0E0 with default widths: flags clear, interrupt enable 0, priority all ones (7), mode 00 (kernel). The reject output is 0.
- R2: On an edge where `flag_upd_i` is 1, bit 0 of `status_o` (C) takes the value of `carry_i`.
- R3: On an edge where `flag_upd_i` is 1, bit 1 (V) takes the value of `ovf_i`.
- R4: On an edge where `flag_upd_i` is 1, bit 3 (N) takes the most significant bit of `alu_res_i`.
- R5: On an edge where `flag_upd_i` is 1, bit 2 (Z) becomes 1 exactly when `alu_res_i` is all zeros.
- R6: On an edge where `flag_upd_i` is 0, bits 3:0 keep their values whatever the datapath inputs carry.
- R7: A control write (`ctl_we_i` = 1) made while the mode field is 00 (kernel) loads bit 4 (interrupt enable), bits 7:5 (priority) and bits 9:8 (mode) from the write inputs. The new values appear after that edge. Without a write, these fields hold.
- R8: A control write made while the mode field is not 00 changes none of bits 9:4.
- R9: `wr_reject_o` is 1 for exactly the one cycle after an edge that saw a control write in a non-kernel mode. It is 0 after kernel writes and after cycles with no write.
- R10: A flag update and a kernel control write on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_upd_i | input | 1 | Flag update strobe (stream valid, always accepted) |
| alu_res_i | input | DATA_W | Arithmetic result from the datapath |
| carry_i | input | 1 | Carry-out of the operation |
| ovf_i | input | 1 | Signed overflow of the operation |
| ctl_we_i | input | 1 | Control field write enable |
| ctl_ien_i | input | 1 | Interrupt enable value to write |
| ctl_prio_i | input | PRIO_W | Priority value to write |
| ctl_mode_i | input | MODE_W | Mode value to write (00 = kernel) |
| status_o | output | 5+PRIO_W+MODE_W | Packed status word {mode, prio, ien, N, Z, V, C} |
| wr_reject_o | output | 1 | One-cycle pulse after a refused control write |

## Verification
A corrupted flag register shows on `status_o[3:0]` one cycle after the strobe that loaded it. A stuck or missing hold enable shows on the first unstrobed cycle, because the datapath inputs keep changing underneath. A wrong privilege check shows in two ways one cycle after the write edge: the control bits of `status_o` change when they should not, and the reject pulse appears or stays missing. A wrong reset value is visible on the first read after reset, before any stimulus.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

  // Condition flags, most significant first, as packed into the status word
  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } cond_flags_t;

  localparam int unsigned FLAG_W = $bits(cond_flags_t);

endpackage

// File: rtl/cond_flag_capture.sv
module cond_flag_capture
  import cpu_status_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output cond_flags_t       flags_o
);

  localparam int unsigned MSB = DATA_W - 1;

  cond_flags_t flags_q;
  cond_flags_t flags_d;

  always_comb begin
    flags_d       = flags_q;
    if (upd_i) begin
      flags_d.neg   = res_i[MSB];
      flags_d.zero  = ~|res_i;
      flags_d.ovf   = ovf_i;
      flags_d.carry = carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_q)); // R6
  AST_CARRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> flags_q.carry == $past(carry_i)); // R2
  AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> flags_q.ovf == $past(ovf_i)); // R3
  AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> flags_q.zero == ($past(res_i) == '0)); // R5

endmodule

// File: rtl/ctrl_field_guard.sv
module ctrl_field_guard #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              ien_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              ien_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              reject_o
);

  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;
  localparam logic [PRIO_W-1:0] PRIO_RESET  = '1;

  logic              ien_q;
  logic [PRIO_W-1:0] prio_q;
  logic [MODE_W-1:0] mode_q;
  logic              reject_q;
  logic              privileged;
  logic              accept;

  assign privileged = (mode_q == MODE_KERNEL);
  assign accept     = we_i && privileged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      prio_q   <= PRIO_RESET;
      mode_q   <= MODE_KERNEL;
      reject_q <= 1'b0;
    end else begin
      reject_q <= we_i && !privileged;
      if (accept) begin
        ien_q  <= ien_i;
        prio_q <= prio_i;
        mode_q <= mode_i;
      end
    end
  end

  assign ien_o    = ien_q;
  assign prio_o   = prio_q;
  assign mode_o   = mode_q;
  assign reject_o = reject_q;

  AST_USER_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && mode_q != MODE_KERNEL) |=> $stable({ien_q, prio_q, mode_q})); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable({ien_q, prio_q, mode_q})); // R7
  AST_KERNEL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && mode_q == MODE_KERNEL) |=> prio_q == $past(prio_i)); // R7
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> $past(we_i && mode_q != MODE_KERNEL)); // R9

endmodule

// File: rtl/status_pack.sv
module status_pack
  import cpu_status_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned MODE_W = 2
) (
  input  cond_flags_t                     flags_i,
  input  logic                            ien_i,
  input  logic [PRIO_W-1:0]               prio_i,
  input  logic [MODE_W-1:0]               mode_i,
  output logic [FLAG_W+1+PRIO_W+MODE_W-1:0] word_o
);

  assign word_o = {mode_i, prio_i, ien_i, flags_i};

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import cpu_status_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned STAT_W = FLAG_W + 1 + PRIO_W + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_upd_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              ctl_we_i,
  input  logic              ctl_ien_i,
  input  logic [PRIO_W-1:0] ctl_prio_i,
  input  logic [MODE_W-1:0] ctl_mode_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wr_reject_o
);

  cond_flags_t       flags;
  logic              ien;
  logic [PRIO_W-1:0] prio;
  logic [MODE_W-1:0] mode;

  cond_flag_capture #(.DATA_W(DATA_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (flag_upd_i),
    .res_i   (alu_res_i),
    .carry_i (carry_i),
    .ovf_i   (ovf_i),
    .flags_o (flags)
  );

  ctrl_field_guard #(.PRIO_W(PRIO_W), .MODE_W(MODE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (ctl_we_i),
    .ien_i    (ctl_ien_i),
    .prio_i   (ctl_prio_i),
    .mode_i   (ctl_mode_i),
    .ien_o    (ien),
    .prio_o   (prio),
    .mode_o   (mode),
    .reject_o (wr_reject_o)
  );

  status_pack #(.PRIO_W(PRIO_W), .MODE_W(MODE_W)) u_pack (
    .flags_i (flags),
    .ien_i   (ien),
    .prio_i  (prio),
    .mode_i  (mode),
    .word_o  (status_o)
  );

  AST_NEG_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd_i |=> status_o[3] == $past(alu_res_i[DATA_W-1])); // R4
  AST_FLAGS_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_i && ctl_we_i) |=> status_o[0] == $past(carry_i)); // R10

endmodule

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_upd_i = 1'b0;
  logic [15:0] alu_res_i = '0;
  logic        carry_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic        ctl_ien_i = 1'b0;
  logic [2:0]  ctl_prio_i = '0;
  logic [1:0]  ctl_mode_i = '0;
  logic [9:0]  status_o;
  logic        wr_reject_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (
    .clk(clk), .rst_n(rst_n), .flag_upd_i(flag_upd_i), .alu_res_i(alu_res_i),
    .carry_i(carry_i), .ovf_i(ovf_i), .ctl_we_i(ctl_we_i), .ctl_ien_i(ctl_ien_i),
    .ctl_prio_i(ctl_prio_i), .ctl_mode_i(ctl_mode_i), .status_o(status_o),
    .wr_reject_o(wr_reject_o)
  );

  // {upd, result[15:0], carry, ovf, expected {N,Z,V,C}}
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 16'h0000, 1'b0, 1'b0, 4'b0100},
    {1'b1, 16'h8000, 1'b1, 1'b1, 4'b1011},
    {1'b1, 16'h7FFF, 1'b0, 1'b1, 4'b0010},
    {1'b0, 16'h0000, 1'b1, 1'b1, 4'b0010},
    {1'b1, 16'hFFFF, 1'b1, 1'b0, 4'b1001},
    {1'b1, 16'h0001, 1'b0, 1'b0, 4'b0000},
    {1'b0, 16'h8000, 1'b1, 1'b1, 4'b0000},
    {1'b1, 16'h0000, 1'b1, 1'b0, 4'b0101}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    flag_upd_i = 1'b0;
    ctl_we_i = 1'b0;
    #10;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    do_reset();
    check("R1 reset word", 32'(status_o), 32'h0E0);
    check("R1 reset reject", 32'(wr_reject_o), 0);

    for (int i = 0; i < 8; i++) begin
      flag_upd_i = VEC[i][22];
      alu_res_i  = VEC[i][21:6];
      carry_i    = VEC[i][5];
      ovf_i      = VEC[i][4];
      step();
      if (VEC[i][22]) begin
        check("R2 carry", 32'(status_o[0]), 32'(VEC[i][0]));
        check("R3 overflow", 32'(status_o[1]), 32'(VEC[i][1]));
        check("R5 zero", 32'(status_o[2]), 32'(VEC[i][2]));
        check("R4 negative", 32'(status_o[3]), 32'(VEC[i][3]));
      end else begin
        check("R6 flags hold", 32'(status_o[3:0]), 32'(VEC[i][3:0]));
      end
    end
    flag_upd_i = 1'b0;

    // Kernel write: ien=1, prio=3, mode=01
    ctl_we_i = 1'b1; ctl_ien_i = 1'b1; ctl_prio_i = 3'd3; ctl_mode_i = 2'b01;
    step();
    check("R7 kernel write fields", 32'(status_o[9:4]), 32'b01_011_1);
    check("R9 no reject on kernel write", 32'(wr_reject_o), 0);
    check("R6 flags untouched by write", 32'(status_o[3:0]), 32'b0101);

    // User-mode write attempt
    ctl_ien_i = 1'b0; ctl_prio_i = 3'd5; ctl_mode_i = 2'b00;
    step();
    check("R8 user write ignored", 32'(status_o[9:4]), 32'b01_011_1);
    check("R9 reject pulse", 32'(wr_reject_o), 1);
    ctl_we_i = 1'b0;
    step();
    check("R9 reject one cycle", 32'(wr_reject_o), 0);
    check("R8 fields still held", 32'(status_o[9:4]), 32'b01_011_1);

    // Reset returns to kernel defaults
    do_reset();
    check("R1 reset after use", 32'(status_o), 32'h0E0);

    // Simultaneous flag update and kernel write
    flag_upd_i = 1'b1; alu_res_i = 16'h8000; carry_i = 1'b1; ovf_i = 1'b0;
    ctl_we_i = 1'b1; ctl_ien_i = 1'b1; ctl_prio_i = 3'd0; ctl_mode_i = 2'b00;
    step();
    check("R10 both applied", 32'(status_o), 32'b00_000_1_1001);
    check("R9 no reject", 32'(wr_reject_o), 0);

    // Kernel rewrite while flags idle with noisy inputs
    flag_upd_i = 1'b0; alu_res_i = 16'h0000; carry_i = 1'b0; ovf_i = 1'b1;
    ctl_ien_i = 1'b0; ctl_prio_i = 3'd6; ctl_mode_i = 2'b10;
    step();
    check("R7 second kernel write", 32'(status_o[9:4]), 32'b10_110_0);
    check("R6 flags hold", 32'(status_o[3:0]), 32'b1001);
    ctl_we_i = 1'b0;
    step();
    check("R7 fields hold without write", 32'(status_o[9:4]), 32'b10_110_0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule